// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block is the part of an 8-bit processor core that moves the program counter and the status byte through the stack page. It takes one command at a time: power-on restart, non-maskable interrupt, maskable interrupt, software break, subroutine call, subroutine return and interrupt return. For each command it runs a short fixed sequence of single-byte accesses on a memory port. Stack pushes and pulls use an 8-bit stack pointer inside the block. Handler addresses are read as two-byte little-endian words from fixed locations at the top of memory.

The surrounding core supplies the current program counter, the current status byte and, for a call, the target address. The block returns the new program counter and status byte and raises `done` for one cycle when the command completes. The next command can be issued in that same cycle. A command that arrives while a sequence is running is dropped.

Top module: `stk_irq_seq`

## Requirements
- R1: A push writes address `STACK_BASE | sp` and then decrements `sp`. A pull first increments `sp` and reads `STACK_BASE | (sp+1)`. `sp_out` shows the pointer.
- R2: Interrupt entry (`cmd_op` 1 = NMI, 2 = IRQ, 3 = break) writes the PC high byte, then the PC low byte, then the status byte, on three consecutive cycles. It then reads the vector low byte and the high byte on the next two cycles. `done` comes in the 7th cycle after acceptance, with `pc_out` = {high,low}.
- R3: The vector low bytes are at FFFA for NMI, FFFC for restart, and FFFE for both IRQ and break. Each high byte sits at the next address.
- R4: The pushed status byte is `flags_in` with bit 4 forced to 1 for break and to 0 for NMI and IRQ. On completion, `flags_out` equals the pushed byte with bit 2 set.
- R5: Restart (`cmd_op` 0) sets `sp` to FF and `flags_out` to 00 at acceptance. It performs no writes, reads FFFC and then FFFD, and raises `done` in the 4th cycle.
- R6: Call (`cmd_op` 4) pushes `pc_in`+2, high byte first, on two cycles. It raises `done` in the 3rd cycle with `pc_out` = `cmd_target`.
- R7: Subroutine return (`cmd_op` 5) pulls the low byte and then the high byte. It raises `done` in the 4th cycle with `pc_out` = pulled word + 1, modulo 65536.
- R8: Interrupt return (`cmd_op` 6) pulls the status byte, then the low byte, then the high byte. It raises `done` in the 5th cycle with `flags_out` = pulled status and `pc_out` = pulled word, without increment.
- R9: At most one of `mem_wr` and `mem_rd` is high in a cycle. Read data is taken from `mem_rdata` in the cycle after `mem_rd`.
- R10: `done` is a one-cycle pulse. A command is accepted only when the block is idle or in its `done` cycle. A command arriving at any other time, and `cmd_op` 7 at any time, causes no access and leaves `sp_out`, `pc_out` and `flags_out` unchanged.
- R11: The stack pointer wraps modulo 256: a push at 00 leaves FF, and a pull at FF reads `STACK_BASE | 00`.
- R12: After reset, `sp_out` = FF, `pc_out` = 0000, `flags_out` = 00, `done` = 0, and there is no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, one cycle |
| cmd_op | input | 3 | Command code (0 restart, 1 NMI, 2 IRQ, 3 break, 4 call, 5 return, 6 interrupt return, 7 none) |
| cmd_target | input | 16 | Call destination |
| pc_in | input | 16 | Current program counter |
| flags_in | input | 8 | Current status byte |
| mem_addr | output | 16 | Memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| pc_out | output | 16 | Resulting program counter |
| flags_out | output | 8 | Resulting status byte |
| sp_out | output | 8 | Stack pointer |
| done | output | 1 | Command complete pulse |

## Verification
Two events can share one cycle. The first is the completion of one command together with the acceptance of the next. The second is a running sequence together with a fresh request that must be dropped. The bench issues each new command in exactly the cycle its model expects `done`, so back-to-back sequences are exercised without any gap. It also raises a second request one cycle into a call. Each cycle is judged against a behavioural queue of expected bus transfers, pointer values and results. That queue lets a dropped request be seen as the absence of any extra access and an unchanged pointer.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_NMI   = 3'd1,
    OP_IRQ   = 3'd2,
    OP_BRK   = 3'd3,
    OP_JSR   = 3'd4,
    OP_RTS   = 3'd5,
    OP_RTI   = 3'd6,
    OP_NONE  = 3'd7
  } seq_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_H,
    ST_PUSH_L,
    ST_PUSH_P,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_PULL_P,
    ST_PULL_L,
    ST_PULL_H,
    ST_CAP_H,
    ST_FIN
  } seq_st_e;

  // which byte the previous cycle read, to be captured this cycle
  typedef enum logic [1:0] {
    RK_NONE,
    RK_FLG,
    RK_LO,
    RK_HI
  } rd_kind_e;

  typedef enum logic [1:0] {
    SP_HOLD,
    SP_INIT,
    SP_INC,
    SP_DEC
  } sp_cmd_e;

  localparam int FLG_I_BIT = 2;
  localparam int FLG_B_BIT = 4;

endpackage

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
  import stk_seq_pkg::*;
#(
  parameter int SP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  sp_cmd_e         cmd,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_up
);

  logic [SP_W-1:0] sp_d;
  logic            sp_en;

  always_comb begin
    sp_up = sp_q + SP_W'(1);
    sp_en = (cmd != SP_HOLD);
    unique case (cmd)
      SP_INIT: sp_d = '1;
      SP_INC:  sp_d = sp_up;
      SP_DEC:  sp_d = sp_q - SP_W'(1);
      default: sp_d = sp_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '1;
    else if (sp_en) sp_q <= sp_d;
  end

endmodule

// File: rtl/stk_seq_ctl.sv
module stk_seq_ctl
  import stk_seq_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_target,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [DATA_W-1:0] sp,
  input  logic [DATA_W-1:0] sp_up,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [DATA_W-1:0] mem_wdata,
  output sp_cmd_e           sp_cmd,
  output rd_kind_e          rd_kind,
  output logic              add_one,
  output logic              ld_flags,
  output logic [DATA_W-1:0] flags_val,
  output logic              ld_pc,
  output logic [ADDR_W-1:0] pc_val,
  output logic              done
);

  localparam logic [ADDR_W-1:0] VEC_TOP = '1;
  localparam logic [ADDR_W-1:0] VEC_NMI = VEC_TOP - ADDR_W'(5);
  localparam logic [ADDR_W-1:0] VEC_RST = VEC_TOP - ADDR_W'(3);
  localparam logic [ADDR_W-1:0] VEC_IRQ = VEC_TOP - ADDR_W'(1);

  seq_st_e           st_q, st_d;
  seq_op_e           op_q, op_in;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] tgt_q;
  logic [DATA_W-1:0] pf_q, pf_d;
  logic              ready, accept;
  logic [ADDR_W-1:0] vec_lo;
  logic [ADDR_W-1:0] push_addr, pull_addr;

  // next-state logic
  always_comb begin
    op_in  = seq_op_e'(cmd_op);
    ready  = (st_q == ST_IDLE) || (st_q == ST_FIN);
    accept = cmd_valid && ready && (op_in != OP_NONE);
    pc_d   = (op_in == OP_JSR) ? pc_in + ADDR_W'(2) : pc_in;
    pf_d   = flags_in;
    pf_d[FLG_B_BIT] = (op_in == OP_BRK);

    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_FIN: begin
        st_d = ST_IDLE;
        if (accept) begin
          unique case (op_in)
            OP_RESET: st_d = ST_VEC_LO;
            OP_RTS:   st_d = ST_PULL_L;
            OP_RTI:   st_d = ST_PULL_P;
            default:  st_d = ST_PUSH_H;
          endcase
        end
      end
      ST_PUSH_H: st_d = ST_PUSH_L;
      ST_PUSH_L: st_d = (op_q == OP_JSR) ? ST_FIN : ST_PUSH_P;
      ST_PUSH_P: st_d = ST_VEC_LO;
      ST_VEC_LO: st_d = ST_VEC_HI;
      ST_VEC_HI: st_d = ST_CAP_H;
      ST_PULL_P: st_d = ST_PULL_L;
      ST_PULL_L: st_d = ST_PULL_H;
      ST_PULL_H: st_d = ST_CAP_H;
      ST_CAP_H:  st_d = ST_FIN;
      default:   st_d = ST_IDLE;
    endcase
  end

  // state and command registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_NONE;
      pc_q  <= '0;
      tgt_q <= '0;
      pf_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q  <= op_in;
        pc_q  <= pc_d;
        tgt_q <= cmd_target;
        pf_q  <= pf_d;
      end
    end
  end

  // bus and side-effect decode
  always_comb begin
    push_addr = STACK_BASE | ADDR_W'(sp);
    pull_addr = STACK_BASE | ADDR_W'(sp_up);
    unique case (op_q)
      OP_NMI:   vec_lo = VEC_NMI;
      OP_RESET: vec_lo = VEC_RST;
      default:  vec_lo = VEC_IRQ;
    endcase

    mem_addr  = '0;
    mem_wr    = 1'b0;
    mem_rd    = 1'b0;
    mem_wdata = '0;
    sp_cmd    = SP_HOLD;
    rd_kind   = RK_NONE;
    ld_flags  = 1'b0;
    flags_val = '0;
    ld_pc     = 1'b0;
    pc_val    = tgt_q;
    add_one   = (op_q == OP_RTS);
    done      = (st_q == ST_FIN);

    unique case (st_q)
      ST_IDLE, ST_FIN: begin
        if (accept && op_in == OP_RESET) begin
          sp_cmd   = SP_INIT;
          ld_flags = 1'b1;
        end
      end
      ST_PUSH_H: begin
        mem_wr    = 1'b1;
        mem_addr  = push_addr;
        mem_wdata = pc_q[ADDR_W-1 -: DATA_W];
        sp_cmd    = SP_DEC;
      end
      ST_PUSH_L: begin
        mem_wr    = 1'b1;
        mem_addr  = push_addr;
        mem_wdata = pc_q[DATA_W-1:0];
        sp_cmd    = SP_DEC;
        ld_pc     = (op_q == OP_JSR);
      end
      ST_PUSH_P: begin
        mem_wr    = 1'b1;
        mem_addr  = push_addr;
        mem_wdata = pf_q;
        sp_cmd    = SP_DEC;
        ld_flags  = 1'b1;
        flags_val = pf_q;
        flags_val[FLG_I_BIT] = 1'b1;
      end
      ST_VEC_LO: begin
        mem_rd   = 1'b1;
        mem_addr = vec_lo;
        rd_kind  = RK_LO;
      end
      ST_VEC_HI: begin
        mem_rd   = 1'b1;
        mem_addr = vec_lo + ADDR_W'(1);
        rd_kind  = RK_HI;
      end
      ST_PULL_P, ST_PULL_L, ST_PULL_H: begin
        mem_rd   = 1'b1;
        mem_addr = pull_addr;
        sp_cmd   = SP_INC;
        rd_kind  = (st_q == ST_PULL_P) ? RK_FLG :
                   (st_q == ST_PULL_L) ? RK_LO  : RK_HI;
      end
      default: ;
    endcase
  end

  // R5: a restart command leaves the pointer at all ones
  a_r5_reset_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_in == OP_RESET) |=> (sp == '1));

endmodule

// File: rtl/stk_result.sv
module stk_result
  import stk_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_kind_e          rd_kind,
  input  logic [DATA_W-1:0] rdata,
  input  logic              add_one,
  input  logic              ld_flags,
  input  logic [DATA_W-1:0] flags_val,
  input  logic              ld_pc,
  input  logic [ADDR_W-1:0] pc_val,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] flags_q
);

  rd_kind_e          kind_q;
  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] pc_d;
  logic [DATA_W-1:0] flags_d;
  logic              pc_en, flags_en, lo_en;

  always_comb begin
    lo_en    = (kind_q == RK_LO);
    pc_en    = ld_pc || (kind_q == RK_HI);
    flags_en = ld_flags || (kind_q == RK_FLG);
    pc_d     = ld_pc ? pc_val
                     : {rdata, lo_q} + (add_one ? ADDR_W'(1) : ADDR_W'(0));
    flags_d  = ld_flags ? flags_val : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= RK_NONE;
      lo_q    <= '0;
      pc_q    <= '0;
      flags_q <= '0;
    end else begin
      kind_q <= rd_kind;
      if (lo_en)    lo_q    <= rdata;
      if (pc_en)    pc_q    <= pc_d;
      if (flags_en) flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/stk_irq_seq.sv
module stk_irq_seq
  import stk_seq_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_target,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] flags_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] flags_out,
  output logic [DATA_W-1:0] sp_out,
  output logic              done
);

  localparam int SP_W = DATA_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  sp_cmd_e           sp_cmd;
  rd_kind_e          rd_kind;
  logic [SP_W-1:0]   sp_up;
  logic              add_one, ld_flags, ld_pc;
  logic [DATA_W-1:0] flags_val;
  logic [ADDR_W-1:0] pc_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  stk_ptr_unit #(.SP_W(SP_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cmd   (sp_cmd),
    .sp_q  (sp_out),
    .sp_up (sp_up)
  );

  stk_seq_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STACK_BASE(STACK_BASE)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_target (cmd_target),
    .pc_in      (pc_in),
    .flags_in   (flags_in),
    .sp         (sp_out),
    .sp_up      (sp_up),
    .mem_addr   (mem_addr),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_wdata  (mem_wdata),
    .sp_cmd     (sp_cmd),
    .rd_kind    (rd_kind),
    .add_one    (add_one),
    .ld_flags   (ld_flags),
    .flags_val  (flags_val),
    .ld_pc      (ld_pc),
    .pc_val     (pc_val),
    .done       (done)
  );

  stk_result #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_kind   (rd_kind),
    .rdata     (mem_rdata),
    .add_one   (add_one),
    .ld_flags  (ld_flags),
    .flags_val (flags_val),
    .ld_pc     (ld_pc),
    .pc_val    (pc_val),
    .pc_q      (pc_out),
    .flags_q   (flags_out)
  );

  // R1: writes land on the page slot named by the pointer
  a_r1_push_addr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr |-> (mem_addr == (STACK_BASE | ADDR_W'(sp_out))));

  // R1: each write is followed by a pointer decrement
  a_r1_push_dec: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr |=> (sp_out == $past(sp_out) - SP_W'(1)));

  // R1: each stack-page read is paired with a pointer increment
  a_r1_pull_inc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_rd && mem_addr[ADDR_W-1:DATA_W] == STACK_BASE[ADDR_W-1:DATA_W])
      |=> (sp_out == $past(sp_out) + SP_W'(1)));

  // R9: one port operation per cycle
  a_r9_one_port_op: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_wr && mem_rd));

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

endmodule

// File: tb/stk_irq_seq_bench.sv
`timescale 1ns/1ps
module stk_irq_seq_bench;

  localparam logic [15:0] BASE = 16'h0100;
  localparam int WDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd7;
  logic [15:0] cmd_target = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  flags_in = '0;
  logic [15:0] mem_addr;
  logic        mem_wr, mem_rd, done;
  logic [7:0]  mem_wdata, flags_out, sp_out;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] pc_out;

  always #2 clk = ~clk;

  stk_irq_seq u_stk_irq_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .pc_in(pc_in), .flags_in(flags_in),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_out(pc_out),
    .flags_out(flags_out), .sp_out(sp_out), .done(done)
  );

  // memory seen by the design, read latency of one cycle (R9)
  logic [7:0] dmem [logic [15:0]];
  // memory image kept by the reference model
  logic [7:0] rmem [logic [15:0]];

  function automatic logic [7:0] dget(input logic [15:0] a);
    return dmem.exists(a) ? dmem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rget(input logic [15:0] a);
    return rmem.exists(a) ? rmem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_wr) dmem[mem_addr] = mem_wdata;
    if (mem_rd) mem_rdata <= dget(mem_addr);
  end

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        dn;
    logic [7:0]  sp;
  } rec_t;

  rec_t  eq[$];
  string rq[$];
  logic [7:0]  m_sp = 8'hFF;
  logic [15:0] m_pc = '0;
  logic [7:0]  m_flags = '0;
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      miscompares++;
      $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic add(input logic wr, input logic rd, input logic [15:0] a,
                     input logic [7:0] wd, input logic dn, input logic [7:0] sp,
                     input string r);
    rec_t x;
    x.wr = wr; x.rd = rd; x.addr = a; x.wd = wd; x.dn = dn; x.sp = sp;
    eq.push_back(x);
    rq.push_back(r);
  endtask

  function automatic logic [15:0] sa(input logic [7:0] s);
    return BASE | {8'h00, s};
  endfunction

  task automatic mwrite(input logic [15:0] a, input logic [7:0] d);
    rmem[a] = d;
  endtask

  // reference model: builds the expected cycle list at acceptance time
  task automatic plan(input logic [2:0] op, input logic [15:0] tgt,
                      input logic [15:0] pcin, input logic [7:0] fl);
    logic [7:0]  s, pf;
    logic [15:0] p, vec;
    if (eq.size() != 0 || op == 3'd7) return;   // R10: dropped
    s = m_sp;
    case (op)
      3'd0: begin // R5 R3: restart
        s = 8'hFF;
        add(0, 1, 16'hFFFC, 0, 0, s, "R5 R3");
        add(0, 1, 16'hFFFD, 0, 0, s, "R5 R3");
        add(0, 0, 0, 0, 0, s, "R5");
        add(0, 0, 0, 0, 1, s, "R5");
        m_sp = s; m_flags = 8'h00;
        m_pc = {rget(16'hFFFD), rget(16'hFFFC)};
      end
      3'd1, 3'd2, 3'd3: begin // R2 R3 R4 R1: interrupt entry
        pf = fl;
        pf[4] = (op == 3'd3);
        vec = (op == 3'd1) ? 16'hFFFA : 16'hFFFE;
        add(1, 0, sa(s), pcin[15:8], 0, s, "R2 R1");
        mwrite(sa(s), pcin[15:8]);
        add(1, 0, sa(s - 8'd1), pcin[7:0], 0, s - 8'd1, "R2 R1");
        mwrite(sa(s - 8'd1), pcin[7:0]);
        add(1, 0, sa(s - 8'd2), pf, 0, s - 8'd2, "R4 R2");
        mwrite(sa(s - 8'd2), pf);
        add(0, 1, vec, 0, 0, s - 8'd3, "R3 R2");
        add(0, 1, vec + 16'd1, 0, 0, s - 8'd3, "R3 R2");
        add(0, 0, 0, 0, 0, s - 8'd3, "R2");
        add(0, 0, 0, 0, 1, s - 8'd3, "R2 R4");
        m_sp = s - 8'd3;
        m_flags = pf | 8'h04;
        m_pc = {rget(vec + 16'd1), rget(vec)};
      end
      3'd4: begin // R6 R1: call
        p = pcin + 16'd2;
        add(1, 0, sa(s), p[15:8], 0, s, "R6 R1");
        mwrite(sa(s), p[15:8]);
        add(1, 0, sa(s - 8'd1), p[7:0], 0, s - 8'd1, "R6 R1");
        mwrite(sa(s - 8'd1), p[7:0]);
        add(0, 0, 0, 0, 1, s - 8'd2, "R6");
        m_sp = s - 8'd2; m_pc = tgt;
      end
      3'd5: begin // R7 R9 R1: subroutine return
        add(0, 1, sa(s + 8'd1), 0, 0, s, "R7 R1");
        add(0, 1, sa(s + 8'd2), 0, 0, s + 8'd1, "R7 R1");
        add(0, 0, 0, 0, 0, s + 8'd2, "R7");
        add(0, 0, 0, 0, 1, s + 8'd2, "R7 R9");
        m_pc = {rget(sa(s + 8'd2)), rget(sa(s + 8'd1))} + 16'd1;
        m_sp = s + 8'd2;
      end
      default: begin // R8 R9: interrupt return
        add(0, 1, sa(s + 8'd1), 0, 0, s, "R8 R1");
        add(0, 1, sa(s + 8'd2), 0, 0, s + 8'd1, "R8 R1");
        add(0, 1, sa(s + 8'd3), 0, 0, s + 8'd2, "R8 R1");
        add(0, 0, 0, 0, 0, s + 8'd3, "R8");
        add(0, 0, 0, 0, 1, s + 8'd3, "R8 R9");
        m_flags = rget(sa(s + 8'd1));
        m_pc = {rget(sa(s + 8'd3)), rget(sa(s + 8'd2))};
        m_sp = s + 8'd3;
      end
    endcase
  endtask

  task automatic compare();
    rec_t  e;
    string r;
    logic  chk, bad;
    if (eq.size() > 0) begin
      e = eq.pop_front();
      r = rq.pop_front();
      chk = e.dn;
    end else begin
      e = '0;
      e.sp = m_sp;
      r = "R10/R12";
      chk = 1'b1;
    end
    vectors++;
    bad = 1'b0;
    if (mem_wr !== e.wr) begin bad = 1; $display("FAIL %s mem_wr got %0b exp %0b", r, mem_wr, e.wr); end
    if (mem_rd !== e.rd) begin bad = 1; $display("FAIL %s mem_rd got %0b exp %0b", r, mem_rd, e.rd); end
    if (done !== e.dn) begin bad = 1; $display("FAIL %s done got %0b exp %0b", r, done, e.dn); end
    if (sp_out !== e.sp) begin bad = 1; $display("FAIL %s sp_out got %02h exp %02h", r, sp_out, e.sp); end
    if ((e.wr || e.rd) && mem_addr !== e.addr) begin
      bad = 1; $display("FAIL %s mem_addr got %04h exp %04h", r, mem_addr, e.addr);
    end
    if (e.wr && mem_wdata !== e.wd) begin
      bad = 1; $display("FAIL %s mem_wdata got %02h exp %02h", r, mem_wdata, e.wd);
    end
    if (chk && pc_out !== m_pc) begin
      bad = 1; $display("FAIL %s pc_out got %04h exp %04h", r, pc_out, m_pc);
    end
    if (chk && flags_out !== m_flags) begin
      bad = 1; $display("FAIL %s flags_out got %02h exp %02h", r, flags_out, m_flags);
    end
    if (bad) miscompares++;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] tgt,
                       input logic [15:0] pcin, input logic [7:0] fl);
    cmd_valid = 1'b1; cmd_op = op; cmd_target = tgt; pc_in = pcin; flags_in = fl;
    plan(op, tgt, pcin, fl);
    tick();
    cmd_valid = 1'b0; cmd_op = 3'd7;
  endtask

  // runs until the expected done cycle has just been checked
  task automatic finish_cmd();
    while (eq.size() != 0) tick();
  endtask

  task automatic preload(input logic [15:0] a, input logic [7:0] d);
    dmem[a] = d; rmem[a] = d;
  endtask

  initial begin
    preload(16'hFFFA, 8'h34); preload(16'hFFFB, 8'hC1);
    preload(16'hFFFC, 8'h00); preload(16'hFFFD, 8'h80);
    preload(16'hFFFE, 8'h78); preload(16'hFFFF, 8'hE5);
    preload(16'h0100, 8'h21); preload(16'h0101, 8'h43);

    // R12: reset state while held and after release
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (5) tick();

    // R11: pull with pointer at FF wraps to slot 00, then 01
    issue(3'd5, 16'h0, 16'h0, 8'h0);
    finish_cmd();
    // R11 R6: call at pointer 01 writes 01 then 00, leaving FF
    issue(3'd4, 16'h1234, 16'h8000, 8'h00);
    finish_cmd();
    // R7: return lands on 8003 (8000 + 2 + 1)
    issue(3'd5, 16'h0, 16'h0, 8'h0);
    finish_cmd();
    repeat (2) tick();

    // R5 R3: restart
    issue(3'd0, 16'h0, 16'hAAAA, 8'hFF);
    finish_cmd();
    // R2 R3 R4: IRQ, then R8 interrupt return, back to back
    issue(3'd2, 16'h0, 16'h9ABC, 8'hD3);
    finish_cmd();
    issue(3'd6, 16'h0, 16'h0, 8'h0);
    finish_cmd();
    // R3 R4: NMI with B set in input, break with B clear in input
    issue(3'd1, 16'h0, 16'h1357, 8'hFF);
    finish_cmd();
    issue(3'd3, 16'h0, 16'h2468, 8'h00);
    finish_cmd();
    issue(3'd6, 16'h0, 16'h0, 8'h0);
    finish_cmd();
    issue(3'd6, 16'h0, 16'h0, 8'h0);
    finish_cmd();
    repeat (3) tick();

    // R10: request one cycle into a call is dropped
    issue(3'd4, 16'h4000, 16'hFFFF, 8'h00);
    issue(3'd2, 16'h0, 16'h5555, 8'h81);
    finish_cmd();
    // R10: code 7 while idle is dropped
    issue(3'd7, 16'hBEEF, 16'h1111, 8'h55);
    repeat (3) tick();
    // R7: return from call at FFFF (pushed 0001)
    issue(3'd5, 16'h0, 16'h0, 8'h0);
    finish_cmd();

    // mixed sequences
    for (int i = 0; i < 60; i++) begin
      logic [2:0] op;
      op = 3'(1 + ($urandom % 6));
      issue(op, 16'($urandom), 16'($urandom), 8'($urandom));
      if (($urandom % 3) == 0) issue(3'(1 + ($urandom % 6)), 16'h0, 16'h0, 8'h0);
      finish_cmd();
      if (($urandom % 4) == 0) tick();
    end
    repeat (3) tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule